// File: doc/BRIEF.md
# Four-Port General-Purpose I/O Controller

This block gives software control of four ports of general-purpose pins through a small 32-bit register bus. Ports 0, 1 and 2 are uniform bidirectional ports: each pin has an output level latch and a direction bit, and its pad value is synchronised and readable. Port 3 combines three kinds of pin: six bidirectional pins, 22 input-only pins and 24 output-only pins. These share register words, and the positions of the bits are fixed.

Levels and directions are never written as whole words. Each latch word has a write-one-to-set address and a write-one-to-clear address. Software can therefore change a single pin without a read-modify-write and without disturbing pins owned by other code. The direction bits of the six port-3 bidirectional pins sit in the upper bits of the port-2 direction word. A port-2 multiplexer word can be set, cleared and read back; it drives no pad.

The bus has no handshake. A write takes effect on the clock edge where the write enable is sampled high. Reads are combinational on the address. The register interface is plain control and status, so no valid/ready is used and there is no back-pressure.

Top module: `gpio_quad_ctrl`

## Requirements
- R1: After reset, every output latch, direction bit and multiplexer bit is 0. All pad outputs and output enables are therefore 0, and every state register that reflects a latch reads 0.
- R2: On a write to a set address, each 1 in the write data forces the matching latch bit to 1, and each 0 leaves its bit unchanged. The set addresses are: port-3 output 0x004, port-2 direction 0x010, port-2 output 0x020, port-2 multiplexer 0x028, port-0 output 0x044, port-0 direction 0x050, port-1 output 0x064 and port-1 direction 0x070.
- R3: On a write to the clear address (set address + 4), each 1 in the write data forces the matching latch bit to 0, and each 0 leaves its bit unchanged.
- R4: Latch state reads back at fixed addresses:
  - port-0 output at 0x04C and direction at 0x058;
  - port-1 output at 0x06C and direction at 0x078;
  - the port-2 direction word at 0x018;
  - the multiplexer word at 0x030;
  - the port-3 output word at 0x00C.

  Bits above a port's pin count read 0. Set and clear addresses read 0, and so does any other offset, aligned or not. Writes to state and input addresses change nothing.
- R5: For ports 0, 1 and 2, pin n's pad output equals output latch bit n and its output enable equals direction bit n. Both follow the latch on the same clock edge that performs the write, with no extra stage. As a result, a level written before the direction is already on the pad when the enable rises.
- R6: Port-3 bidirectional pin n (0..5) has its level at bit n+25 of 0x004/0x008 and its direction at bit n+25 of 0x010/0x014. Both read back at bit n+25 of 0x00C and 0x018 respectively.
- R7: Port-3 output-only pin n (0..23) is driven by bit n of 0x004/0x008 and reads back at bit n of 0x00C. Bits 24 and 31 of 0x00C read 0.
- R8: Every input pin passes through a two-flop synchroniser. A pin value applied before a clock edge is not visible after that first edge, and is visible after the second. Port 0, 1 and 2 pin n reads at bit n of 0x040, 0x060 and 0x01C, whatever the pin's direction.
- R9: The port-3 input word at 0x000 is laid out as follows:
  - input-only pins 0..9 at bits 0..9;
  - input-only pins 10..18 at bits 15..23;
  - input-only pins 19..21 at bits 25..27;
  - bidirectional pins 0..4 at bits 10..14;
  - bidirectional pin 5 at bit 24;
  - bits 28..31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| p0_in | input | P0_W | Port 0 pad inputs |
| p0_out | output | P0_W | Port 0 pad output levels |
| p0_oe | output | P0_W | Port 0 output enables |
| p1_in | input | P1_W | Port 1 pad inputs |
| p1_out | output | P1_W | Port 1 pad output levels |
| p1_oe | output | P1_W | Port 1 output enables |
| p2_in | input | P2_W | Port 2 pad inputs |
| p2_out | output | P2_W | Port 2 pad output levels |
| p2_oe | output | P2_W | Port 2 output enables |
| p3_io_in | input | 6 | Port 3 bidirectional pad inputs |
| p3_io_out | output | 6 | Port 3 bidirectional output levels |
| p3_io_oe | output | 6 | Port 3 bidirectional output enables |
| p3_gpi_in | input | 22 | Port 3 input-only pads |
| p3_gpo_out | output | 24 | Port 3 output-only pad levels |

## Verification
A latch bit that takes the wrong value shows up one clock edge after the write that caused it. It appears at once on the pad output or enable, and in the matching state word, so a walk of every bit through every set and clear address catches it without delay. A wrong bit position, the most likely fault in the scattered port-3 map, makes a walking-one pattern on the pins appear at the wrong bit of the input word or on the wrong pad. A synchroniser that is one flop short or long makes a pin change visible one edge early or late. This is caught by sampling the input word after exactly one edge and again after the second.

// File: rtl/gpio_map_pkg.sv
package gpio_map_pkg;

  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int P3_IO_N   = 6;
  localparam int P3_GPI_N  = 22;
  localparam int P3_GPO_N  = 24;
  localparam int P3_IO_LSB = 25;

  localparam logic [ADDR_W-1:0] A_P3_IN   = 8'h00;
  localparam logic [ADDR_W-1:0] A_P3_OSET = 8'h04;
  localparam logic [ADDR_W-1:0] A_P3_OCLR = 8'h08;
  localparam logic [ADDR_W-1:0] A_P3_OST  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_P2_DSET = 8'h10;
  localparam logic [ADDR_W-1:0] A_P2_DCLR = 8'h14;
  localparam logic [ADDR_W-1:0] A_P2_DST  = 8'h18;
  localparam logic [ADDR_W-1:0] A_P2_IN   = 8'h1C;
  localparam logic [ADDR_W-1:0] A_P2_OSET = 8'h20;
  localparam logic [ADDR_W-1:0] A_P2_OCLR = 8'h24;
  localparam logic [ADDR_W-1:0] A_P2_MSET = 8'h28;
  localparam logic [ADDR_W-1:0] A_P2_MCLR = 8'h2C;
  localparam logic [ADDR_W-1:0] A_P2_MST  = 8'h30;
  localparam logic [ADDR_W-1:0] A_P0_IN   = 8'h40;
  localparam logic [ADDR_W-1:0] A_P0_OSET = 8'h44;
  localparam logic [ADDR_W-1:0] A_P0_OCLR = 8'h48;
  localparam logic [ADDR_W-1:0] A_P0_OST  = 8'h4C;
  localparam logic [ADDR_W-1:0] A_P0_DSET = 8'h50;
  localparam logic [ADDR_W-1:0] A_P0_DCLR = 8'h54;
  localparam logic [ADDR_W-1:0] A_P0_DST  = 8'h58;
  localparam logic [ADDR_W-1:0] A_P1_IN   = 8'h60;
  localparam logic [ADDR_W-1:0] A_P1_OSET = 8'h64;
  localparam logic [ADDR_W-1:0] A_P1_OCLR = 8'h68;
  localparam logic [ADDR_W-1:0] A_P1_OST  = 8'h6C;
  localparam logic [ADDR_W-1:0] A_P1_DSET = 8'h70;
  localparam logic [ADDR_W-1:0] A_P1_DCLR = 8'h74;
  localparam logic [ADDR_W-1:0] A_P1_DST  = 8'h78;

  // Scatter the port-3 inputs into their fixed bit positions
  function automatic logic [DATA_W-1:0] p3_in_word(
    input logic [P3_GPI_N-1:0] gpi,
    input logic [P3_IO_N-1:0]  bio
  );
    logic [DATA_W-1:0] w;
    w         = '0;
    w[9:0]    = gpi[9:0];
    w[14:10]  = bio[4:0];
    w[23:15]  = gpi[18:10];
    w[24]     = bio[5];
    w[27:25]  = gpi[21:19];
    return w;
  endfunction

endpackage

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o | set_i) & ~clr_i;
  end

  // R2
  set_forces_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0 && clr_i == '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R3
  clr_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0 && set_i == '0) |=> ((q_o & $past(clr_i)) == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/gpio_quad_ctrl.sv
module gpio_quad_ctrl
  import gpio_map_pkg::*;
#(
  parameter int P0_W        = 8,
  parameter int P1_W        = 24,
  parameter int P2_W        = 13,
  parameter int MUX_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [P0_W-1:0]   p0_in,
  output logic [P0_W-1:0]   p0_out,
  output logic [P0_W-1:0]   p0_oe,
  input  logic [P1_W-1:0]   p1_in,
  output logic [P1_W-1:0]   p1_out,
  output logic [P1_W-1:0]   p1_oe,
  input  logic [P2_W-1:0]   p2_in,
  output logic [P2_W-1:0]   p2_out,
  output logic [P2_W-1:0]   p2_oe,
  input  logic [P3_IO_N-1:0]  p3_io_in,
  output logic [P3_IO_N-1:0]  p3_io_out,
  output logic [P3_IO_N-1:0]  p3_io_oe,
  input  logic [P3_GPI_N-1:0] p3_gpi_in,
  output logic [P3_GPO_N-1:0] p3_gpo_out
);

  localparam int IN_W   = P0_W + P1_W + P2_W + P3_IO_N + P3_GPI_N;
  localparam int IO_MSB = P3_IO_LSB + P3_IO_N - 1;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31], bus_wdata[24]};

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return bus_we && (bus_addr == a);
  endfunction

  // ---------------- latch banks ----------------
  logic [P3_IO_N-1:0] mux_unused_pad;
  logic [MUX_W-1:0]   mux_q;

  gpio_setclr_bank #(.W(P0_W)) u_p0_out (.clk, .rst_n,
    .set_i(hit(A_P0_OSET) ? bus_wdata[P0_W-1:0] : '0),
    .clr_i(hit(A_P0_OCLR) ? bus_wdata[P0_W-1:0] : '0), .q_o(p0_out));
  gpio_setclr_bank #(.W(P0_W)) u_p0_dir (.clk, .rst_n,
    .set_i(hit(A_P0_DSET) ? bus_wdata[P0_W-1:0] : '0),
    .clr_i(hit(A_P0_DCLR) ? bus_wdata[P0_W-1:0] : '0), .q_o(p0_oe));
  gpio_setclr_bank #(.W(P1_W)) u_p1_out (.clk, .rst_n,
    .set_i(hit(A_P1_OSET) ? bus_wdata[P1_W-1:0] : '0),
    .clr_i(hit(A_P1_OCLR) ? bus_wdata[P1_W-1:0] : '0), .q_o(p1_out));
  gpio_setclr_bank #(.W(P1_W)) u_p1_dir (.clk, .rst_n,
    .set_i(hit(A_P1_DSET) ? bus_wdata[P1_W-1:0] : '0),
    .clr_i(hit(A_P1_DCLR) ? bus_wdata[P1_W-1:0] : '0), .q_o(p1_oe));
  gpio_setclr_bank #(.W(P2_W)) u_p2_out (.clk, .rst_n,
    .set_i(hit(A_P2_OSET) ? bus_wdata[P2_W-1:0] : '0),
    .clr_i(hit(A_P2_OCLR) ? bus_wdata[P2_W-1:0] : '0), .q_o(p2_out));
  gpio_setclr_bank #(.W(P2_W)) u_p2_dir (.clk, .rst_n,
    .set_i(hit(A_P2_DSET) ? bus_wdata[P2_W-1:0] : '0),
    .clr_i(hit(A_P2_DCLR) ? bus_wdata[P2_W-1:0] : '0), .q_o(p2_oe));
  // port-3 bidirectional directions live in the upper port-2 direction bits
  gpio_setclr_bank #(.W(P3_IO_N)) u_p3_dir (.clk, .rst_n,
    .set_i(hit(A_P2_DSET) ? bus_wdata[IO_MSB:P3_IO_LSB] : '0),
    .clr_i(hit(A_P2_DCLR) ? bus_wdata[IO_MSB:P3_IO_LSB] : '0), .q_o(p3_io_oe));
  gpio_setclr_bank #(.W(P3_IO_N)) u_p3_lvl (.clk, .rst_n,
    .set_i(hit(A_P3_OSET) ? bus_wdata[IO_MSB:P3_IO_LSB] : '0),
    .clr_i(hit(A_P3_OCLR) ? bus_wdata[IO_MSB:P3_IO_LSB] : '0), .q_o(p3_io_out));
  gpio_setclr_bank #(.W(P3_GPO_N)) u_p3_gpo (.clk, .rst_n,
    .set_i(hit(A_P3_OSET) ? bus_wdata[P3_GPO_N-1:0] : '0),
    .clr_i(hit(A_P3_OCLR) ? bus_wdata[P3_GPO_N-1:0] : '0), .q_o(p3_gpo_out));
  gpio_setclr_bank #(.W(MUX_W)) u_p2_mux (.clk, .rst_n,
    .set_i(hit(A_P2_MSET) ? bus_wdata[MUX_W-1:0] : '0),
    .clr_i(hit(A_P2_MCLR) ? bus_wdata[MUX_W-1:0] : '0), .q_o(mux_q));

  assign mux_unused_pad = '0;

  // ---------------- input synchroniser ----------------
  logic [IN_W-1:0]     in_s;
  logic [P0_W-1:0]     p0_s;
  logic [P1_W-1:0]     p1_s;
  logic [P2_W-1:0]     p2_s;
  logic [P3_IO_N-1:0]  io_s;
  logic [P3_GPI_N-1:0] gpi_s;

  gpio_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n,
    .d_i({p3_gpi_in, p3_io_in, p2_in, p1_in, p0_in}),
    .q_o(in_s));

  assign {gpi_s, io_s, p2_s, p1_s, p0_s} = in_s;

  // ---------------- read mux ----------------
  always_comb begin
    unique case (bus_addr)
      A_P3_IN:  bus_rdata = p3_in_word(gpi_s, io_s);
      A_P3_OST: bus_rdata = (DATA_W'(p3_io_out) << P3_IO_LSB) | DATA_W'(p3_gpo_out);
      A_P2_DST: bus_rdata = (DATA_W'(p3_io_oe) << P3_IO_LSB) | DATA_W'(p2_oe);
      A_P2_IN:  bus_rdata = DATA_W'(p2_s);
      A_P2_MST: bus_rdata = DATA_W'(mux_q) | DATA_W'(mux_unused_pad);
      A_P0_IN:  bus_rdata = DATA_W'(p0_s);
      A_P0_OST: bus_rdata = DATA_W'(p0_out);
      A_P0_DST: bus_rdata = DATA_W'(p0_oe);
      A_P1_IN:  bus_rdata = DATA_W'(p1_s);
      A_P1_OST: bus_rdata = DATA_W'(p1_out);
      A_P1_DST: bus_rdata = DATA_W'(p1_oe);
      default:  bus_rdata = '0;
    endcase
  end

  // ---------------- checks ----------------
  logic [1:0] edges_since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    edges_since_rst <= '0;
    else if (edges_since_rst != 3) edges_since_rst <= edges_since_rst + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_sync_chk
    // R8
    p0_sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_since_rst >= 2) |-> (p0_s == $past(p0_in, 2)));
    // R9
    gpi_sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_since_rst >= 2) |-> (gpi_s == $past(p3_gpi_in, 2)));
  end

  // R1
  reset_pads_chk: assert property (@(posedge clk)
    (!rst_n) |-> (p0_oe == '0 && p1_oe == '0 && p2_oe == '0 && p3_io_oe == '0));

endmodule

// File: tb/tb_gpio_quad_ctrl.sv
module tb_gpio_quad_ctrl;

  localparam int P0_W = 8, P1_W = 24, P2_W = 13, MUX_W = 3;
  localparam logic [31:0] M0   = (32'd1 << P0_W) - 1;
  localparam logic [31:0] M1   = (32'd1 << P1_W) - 1;
  localparam logic [31:0] M2   = (32'd1 << P2_W) - 1;
  localparam logic [31:0] MMX  = (32'd1 << MUX_W) - 1;
  localparam logic [31:0] MIO  = 32'h3F << 25;
  localparam logic [31:0] MGPO = 32'h00FF_FFFF;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [P0_W-1:0] p0_in = 0, p0_out, p0_oe;
  logic [P1_W-1:0] p1_in = 0, p1_out, p1_oe;
  logic [P2_W-1:0] p2_in = 0, p2_out, p2_oe;
  logic [5:0] p3_io_in = 0, p3_io_out, p3_io_oe;
  logic [21:0] p3_gpi_in = 0;
  logic [23:0] p3_gpo_out;

  gpio_quad_ctrl #(.P0_W(P0_W), .P1_W(P1_W), .P2_W(P2_W), .MUX_W(MUX_W)) dut (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .p0_in, .p0_out, .p0_oe, .p1_in, .p1_out, .p1_oe,
    .p2_in, .p2_out, .p2_oe, .p3_io_in, .p3_io_out, .p3_io_oe,
    .p3_gpi_in, .p3_gpo_out);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // bench model of the latch words
  logic [31:0] m_o0 = 0, m_d0 = 0, m_o1 = 0, m_d1 = 0, m_o2 = 0;
  logic [31:0] m_d2 = 0, m_o3 = 0, m_mx = 0;
  // pin values visible after synchronisation
  logic [31:0] v0 = 0, v1 = 0, v2 = 0, vio = 0, vgpi = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] p3_in_exp();
    logic [31:0] w = 0;
    for (int i = 0; i < 22; i++) begin
      int pos = (i < 10) ? i : ((i < 19) ? i + 5 : i + 6);
      w[pos] = vgpi[i];
    end
    for (int j = 0; j < 6; j++) w[(j == 5) ? 24 : 10 + j] = vio[j];
    return w;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return p3_in_exp();
      8'h0C: return m_o3;
      8'h18: return m_d2;
      8'h1C: return v2;
      8'h30: return m_mx;
      8'h40: return v0;
      8'h4C: return m_o0;
      8'h58: return m_d0;
      8'h60: return v1;
      8'h6C: return m_o1;
      8'h78: return m_d1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic upd(inout logic [31:0] m, input logic [7:0] a, input logic [7:0] sa,
                     input logic [31:0] d, input logic [31:0] mask);
    if (a == sa) m = m | (d & mask);
    else if (a == sa + 8'h4) m = m & ~(d & mask);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    upd(m_o3, a, 8'h04, d, MIO | MGPO);
    upd(m_d2, a, 8'h10, d, MIO | M2);
    upd(m_o2, a, 8'h20, d, M2);
    upd(m_mx, a, 8'h28, d, MMX);
    upd(m_o0, a, 8'h44, d, M0);
    upd(m_d0, a, 8'h50, d, M0);
    upd(m_o1, a, 8'h64, d, M1);
    upd(m_d1, a, 8'h70, d, M1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #2; d = bus_rdata;
  endtask

  task automatic check_pads(input string tag);
    #1;
    check({tag, " R5 p0_out"}, 32'(p0_out), m_o0);
    check({tag, " R5 p0_oe"},  32'(p0_oe),  m_d0);
    check({tag, " R5 p1_out"}, 32'(p1_out), m_o1);
    check({tag, " R5 p1_oe"},  32'(p1_oe),  m_d1);
    check({tag, " R5 p2_out"}, 32'(p2_out), m_o2);
    check({tag, " R5 p2_oe"},  32'(p2_oe),  m_d2 & M2);
    check({tag, " R6 p3_io_out"}, 32'(p3_io_out), m_o3 >> 25);
    check({tag, " R6 p3_io_oe"},  32'(p3_io_oe),  m_d2 >> 25);
    check({tag, " R7 p3_gpo_out"}, 32'(p3_gpo_out), m_o3 & MGPO);
  endtask

  task automatic sweep(input string tag);
    logic [31:0] d;
    for (int a = 0; a < 128; a += 4) begin
      @(negedge clk);
      rd(8'(a), d);
      check($sformatf("%s R4 read %02h", tag, a), d, exp_read(8'(a)));
    end
  endtask

  task automatic drive_pins(input logic [31:0] a0, a1, a2, aio, agpi,
                            input logic [7:0] reg_a, input string tag);
    logic [31:0] d;
    @(negedge clk);
    p0_in = a0[P0_W-1:0]; p1_in = a1[P1_W-1:0]; p2_in = a2[P2_W-1:0];
    p3_io_in = aio[5:0]; p3_gpi_in = agpi[21:0];
    @(negedge clk);
    rd(reg_a, d);
    check({tag, " R8 one edge old"}, d, exp_read(reg_a));
    v0 = a0 & M0; v1 = a1 & M1; v2 = a2 & M2; vio = aio & 32'h3F; vgpi = agpi & 32'h3F_FFFF;
    @(negedge clk);
    rd(reg_a, d);
    check({tag, " R8 R9 two edges new"}, d, exp_read(reg_a));
  endtask

  localparam logic [7:0] SETS [8] = '{8'h04, 8'h10, 8'h20, 8'h28, 8'h44, 8'h50, 8'h64, 8'h70};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_pads("R1 reset");
    sweep("R1 reset");

    // walk every bit through every set then clear address
    for (int r = 0; r < 8; r++) begin
      for (int b = 0; b < 32; b++) begin
        bwrite(SETS[r], 32'd1 << b);
        check_pads($sformatf("R2 set %02h b%0d", SETS[r], b));
        if (b % 8 == 7) sweep("R2 R6 R7");
      end
      for (int b = 0; b < 32; b++) begin
        bwrite(SETS[r] + 8'h4, 32'd1 << b);
        check_pads($sformatf("R3 clr %02h b%0d", SETS[r], b));
      end
      sweep("R3 after clear");
    end

    // patterns: zero bits leave others untouched
    for (int r = 0; r < 8; r++) begin
      bwrite(SETS[r], 32'hA5C3_96F0);
      bwrite(SETS[r], 32'h0);
      bwrite(SETS[r] + 8'h4, 32'h0);
      check_pads("R2 R3 zero write");
      bwrite(SETS[r] + 8'h4, 32'h0F0F_0F0F);
      check_pads("R3 partial clear");
    end
    sweep("R2 R3 pattern");

    // writes to read-only and unmapped addresses change nothing
    bwrite(8'h4C, 32'hFFFF_FFFF);
    bwrite(8'h0C, 32'hFFFF_FFFF);
    bwrite(8'h18, 32'hFFFF_FFFF);
    bwrite(8'h3C, 32'hFFFF_FFFF);
    bwrite(8'h45, 32'hFFFF_FFFF);
    check_pads("R4 ignored writes");
    sweep("R4 ignored writes");

    // level first, then direction: level already present when enable rises
    bwrite(8'h48, 32'hFF); bwrite(8'h54, 32'hFF);
    bwrite(8'h44, 32'h5A);
    check_pads("R5 level before dir");
    bwrite(8'h50, 32'hFF);
    check_pads("R5 oe with level");

    // walking one on each input group
    for (int i = 0; i < P0_W; i++) drive_pins(32'd1 << i, 0, 0, 0, 0, 8'h40, "p0 in");
    for (int i = 0; i < P1_W; i++) drive_pins(0, 32'd1 << i, 0, 0, 0, 8'h60, "p1 in");
    for (int i = 0; i < P2_W; i++) drive_pins(0, 0, 32'd1 << i, 0, 0, 8'h1C, "p2 in");
    for (int i = 0; i < 6; i++)    drive_pins(0, 0, 0, 32'd1 << i, 0, 8'h00, "p3 io in");
    for (int i = 0; i < 22; i++)   drive_pins(0, 0, 0, 0, 32'd1 << i, 8'h00, "p3 gpi in");
    drive_pins(32'hFF, 32'hFFFFFF, 32'h1FFF, 32'h3F, 32'h3FFFFF, 8'h00, "all ones");
    sweep("R8 R9 all ones");
    drive_pins(32'h3C, 32'hA5A5A5, 32'h0AAA, 32'h15, 32'h2AAAAA, 8'h00, "mixed");
    sweep("R8 R9 mixed");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule